// File: doc/BRIEF.md
# Register transfer and test unit

This block is the execute stage for one family of single-byte operations of an 8-bit processor: the moves among the accumulator, the condition register, the 16-bit index pair and the stack pointer, and the zero/negative test of a byte. A sequencer presents a fetched opcode with the current register file on the same cycle as `start_i`. One clock later the unit shows the updated register values, the new condition bits, the number of bus cycles the operation costs and a one-cycle `done_o` strobe.

The 16-bit index pair is `{idx_hi, idx_lo}`. Moves between this pair and the stack pointer add or subtract one. As a result the index pair addresses the last byte written to the stack, while the stack pointer addresses the next free location. For the memory form of the test, the operand byte arrives on `mem_i`, already fetched by logic outside this block. Unknown opcodes raise `illegal_o` and leave every register as it was.

Top module: `xfer_test_unit`

## Requirements
- R1: While `rst_ni` is low, `done_o` and `illegal_o` are 0 and every register output and `cycles_o` reads zero.
- R2: `done_o` is high in exactly the cycle after each cycle with `start_i` high, and low otherwise. Results appear in that same cycle. Outputs hold their values while `start_i` is low.
- R3: Opcode 0x84 loads the condition register from the accumulator, with bits 6 and 5 forced to 1. It costs 1 cycle. The condition layout is V=bit7, H=bit4, I=bit3, N=bit2, Z=bit1, C=bit0.
- R4: Opcode 0x85 loads the accumulator from the condition register. Condition bits are unchanged and the cost is 1 cycle.
- R5: Opcode 0x97 copies the accumulator into `idx_lo`. Opcode 0x9F copies `idx_lo` into the accumulator. Each costs 1 cycle and leaves the condition bits unchanged.
- R6: Opcode 0x95 loads `{idx_hi, idx_lo}` with the stack pointer plus one, modulo 2^16, and costs 2 cycles. The value 0xFFFF therefore gives 0x0000.
- R7: Opcode 0x94 loads the stack pointer with `{idx_hi, idx_lo}` minus one, modulo 2^16, and costs 2 cycles. The value 0x0000 therefore gives 0xFFFF.
- R8: A test operation sets N to operand bit 7, sets Z when the operand is zero, and clears V. It leaves H, I, C, bits 6:5 and every register unchanged.
- R9: The test operand and cost depend on the opcode: 0x4D tests the accumulator in 1 cycle, 0x5D tests `idx_lo` in 1 cycle, and 0x3D tests `mem_i` in 4 cycles.
- R10: Any other opcode sets `illegal_o` together with `done_o` and reports `cycles_o` = 0. All register and condition outputs then equal the inputs that were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept the presented operation |
| opcode_i | input | 8 | Opcode |
| acc_i | input | 8 | Accumulator in |
| idx_lo_i | input | 8 | Index low byte in |
| idx_hi_i | input | 8 | Index high byte in |
| sp_i | input | 16 | Stack pointer in |
| ccr_i | input | 8 | Condition register in |
| mem_i | input | 8 | Memory operand for the memory test |
| done_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Unsupported opcode |
| acc_o | output | 8 | Accumulator out |
| idx_lo_o | output | 8 | Index low byte out |
| idx_hi_o | output | 8 | Index high byte out |
| sp_o | output | 16 | Stack pointer out |
| ccr_o | output | 8 | Condition register out |
| cycles_o | output | 3 | Bus cycle cost |

## Verification
The bench builds the unit with its default data width of 8, so the index pair and stack pointer are 16 bits wide and the cycle field is 3 bits wide. At these widths the bench can force the wrap points 0xFFFF and 0x0000 directly. It can also drive the operands 0x00 and 0x80 for the test flags, and send every opcode byte, both supported and unsupported. Random opcodes and register values are mixed with these directed cases.

// File: rtl/xtu_pkg.sv
package xtu_pkg;
  typedef enum logic [3:0] {
    OP_TAP, OP_TPA, OP_TAX, OP_TXA, OP_TSX, OP_TXS,
    OP_TSTA, OP_TSTX, OP_TSTM, OP_BAD
  } op_e;

  localparam logic [7:0] OPC_TAP  = 8'h84;
  localparam logic [7:0] OPC_TPA  = 8'h85;
  localparam logic [7:0] OPC_TAX  = 8'h97;
  localparam logic [7:0] OPC_TXA  = 8'h9F;
  localparam logic [7:0] OPC_TSX  = 8'h95;
  localparam logic [7:0] OPC_TXS  = 8'h94;
  localparam logic [7:0] OPC_TSTA = 8'h4D;
  localparam logic [7:0] OPC_TSTX = 8'h5D;
  localparam logic [7:0] OPC_TSTM = 8'h3D;

  localparam int CCR_V = 7;
  localparam int CCR_N = 2;
  localparam int CCR_Z = 1;
  localparam logic [7:0] CCR_FIXED = 8'h60;

  function automatic logic is_test(op_e op);
    return (op == OP_TSTA) || (op == OP_TSTX) || (op == OP_TSTM);
  endfunction
endpackage

// File: rtl/xtu_decode.sv
module xtu_decode
  import xtu_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic [7:0]       opcode_i,
  output op_e              op_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic             illegal_o
);
  always_comb begin
    op_o     = OP_BAD;
    cycles_o = '0;
    unique case (opcode_i)
      OPC_TAP:  begin op_o = OP_TAP;  cycles_o = CYC_W'(1); end
      OPC_TPA:  begin op_o = OP_TPA;  cycles_o = CYC_W'(1); end
      OPC_TAX:  begin op_o = OP_TAX;  cycles_o = CYC_W'(1); end
      OPC_TXA:  begin op_o = OP_TXA;  cycles_o = CYC_W'(1); end
      OPC_TSX:  begin op_o = OP_TSX;  cycles_o = CYC_W'(2); end
      OPC_TXS:  begin op_o = OP_TXS;  cycles_o = CYC_W'(2); end
      OPC_TSTA: begin op_o = OP_TSTA; cycles_o = CYC_W'(1); end
      OPC_TSTX: begin op_o = OP_TSTX; cycles_o = CYC_W'(1); end
      OPC_TSTM: begin op_o = OP_TSTM; cycles_o = CYC_W'(4); end
      default:  begin op_o = OP_BAD;  cycles_o = '0; end
    endcase
    illegal_o = (op_o == OP_BAD);
  end
endmodule

// File: rtl/xtu_index.sv
module xtu_index #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] sp_i,
  input  logic [PTR_W-1:0] hx_i,
  output logic [PTR_W-1:0] sp_to_hx_o,
  output logic [PTR_W-1:0] hx_to_sp_o
);
  // modulo 2^PTR_W by truncation
  assign sp_to_hx_o = sp_i + PTR_W'(1);
  assign hx_to_sp_o = hx_i - PTR_W'(1);
endmodule

// File: rtl/xtu_flags.sv
module xtu_flags
  import xtu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] idx_lo_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] ccr_i,
  output logic [DATA_W-1:0] ccr_o
);
  logic [DATA_W-1:0] operand;

  always_comb begin
    unique case (op_i)
      OP_TSTA: operand = acc_i;
      OP_TSTX: operand = idx_lo_i;
      default: operand = mem_i;
    endcase
  end

  always_comb begin
    ccr_o = ccr_i;
    if (op_i == OP_TAP) begin
      ccr_o = acc_i | DATA_W'(CCR_FIXED);
    end else if (is_test(op_i)) begin
      ccr_o[CCR_V] = 1'b0;
      ccr_o[CCR_N] = operand[DATA_W-1];
      ccr_o[CCR_Z] = (operand == '0);
    end
  end
endmodule

// File: rtl/xfer_test_unit.sv
module xfer_test_unit
  import xtu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CYC_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          opcode_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   idx_lo_i,
  input  logic [DATA_W-1:0]   idx_hi_i,
  input  logic [2*DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0]   ccr_i,
  input  logic [DATA_W-1:0]   mem_i,
  output logic                done_o,
  output logic                illegal_o,
  output logic [DATA_W-1:0]   acc_o,
  output logic [DATA_W-1:0]   idx_lo_o,
  output logic [DATA_W-1:0]   idx_hi_o,
  output logic [2*DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0]   ccr_o,
  output logic [CYC_W-1:0]    cycles_o
);
  localparam int PTR_W = 2 * DATA_W;

  op_e              op;
  logic [CYC_W-1:0] dec_cycles;
  logic             dec_illegal;
  logic [PTR_W-1:0] sp_to_hx, hx_to_sp;
  logic [DATA_W-1:0] ccr_nxt, acc_nxt, lo_nxt, hi_nxt;
  logic [PTR_W-1:0] sp_nxt;

  xtu_decode #(.CYC_W(CYC_W)) u_decode (
    .opcode_i (opcode_i),
    .op_o     (op),
    .cycles_o (dec_cycles),
    .illegal_o(dec_illegal)
  );

  xtu_index #(.PTR_W(PTR_W)) u_index (
    .sp_i      (sp_i),
    .hx_i      ({idx_hi_i, idx_lo_i}),
    .sp_to_hx_o(sp_to_hx),
    .hx_to_sp_o(hx_to_sp)
  );

  xtu_flags #(.DATA_W(DATA_W)) u_flags (
    .op_i    (op),
    .acc_i   (acc_i),
    .idx_lo_i(idx_lo_i),
    .mem_i   (mem_i),
    .ccr_i   (ccr_i),
    .ccr_o   (ccr_nxt)
  );

  always_comb begin
    acc_nxt = acc_i;
    lo_nxt  = idx_lo_i;
    hi_nxt  = idx_hi_i;
    sp_nxt  = sp_i;
    unique case (op)
      OP_TPA:  acc_nxt = ccr_i;
      OP_TAX:  lo_nxt  = acc_i;
      OP_TXA:  acc_nxt = idx_lo_i;
      OP_TSX:  {hi_nxt, lo_nxt} = sp_to_hx;
      OP_TXS:  sp_nxt = hx_to_sp;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      acc_o     <= '0;
      idx_lo_o  <= '0;
      idx_hi_o  <= '0;
      sp_o      <= '0;
      ccr_o     <= '0;
      cycles_o  <= '0;
    end else begin
      done_o    <= start_i;
      illegal_o <= start_i && dec_illegal;
      if (start_i) begin
        acc_o    <= acc_nxt;
        idx_lo_o <= lo_nxt;
        idx_hi_o <= hi_nxt;
        sp_o     <= sp_nxt;
        ccr_o    <= ccr_nxt;
        cycles_o <= dec_cycles;
      end
    end
  end

  assert_done_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_no_spurious_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && $stable(acc_o) && $stable(sp_o) && $stable(ccr_o));
  assert_illegal_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && cycles_o == '0);
  assert_illegal_keeps_regs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dec_illegal) |=> acc_o == $past(acc_i) && sp_o == $past(sp_i)
      && ccr_o == $past(ccr_i) && idx_lo_o == $past(idx_lo_i));
  assert_tsx_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && opcode_i == OPC_TSX) |=> {idx_hi_o, idx_lo_o} == $past(sp_i) + PTR_W'(1));
  assert_txs_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && opcode_i == OPC_TXS) |=> sp_o == $past({idx_hi_i, idx_lo_i}) - PTR_W'(1));
  assert_test_clears_v_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (opcode_i == OPC_TSTA || opcode_i == OPC_TSTX || opcode_i == OPC_TSTM))
      |=> !ccr_o[CCR_V] && acc_o == $past(acc_i));
endmodule

// File: tb/xfer_test_unit_test.sv
module xfer_test_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opc = '0, acc = '0, lo = '0, hi = '0, ccr = '0, mem = '0;
  logic [15:0] sp = '0;
  logic done, illegal;
  logic [7:0] acc_q, lo_q, hi_q, ccr_q;
  logic [15:0] sp_q;
  logic [2:0] cyc_q;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_test_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opc),
    .acc_i(acc), .idx_lo_i(lo), .idx_hi_i(hi), .sp_i(sp), .ccr_i(ccr), .mem_i(mem),
    .done_o(done), .illegal_o(illegal), .acc_o(acc_q), .idx_lo_o(lo_q),
    .idx_hi_o(hi_q), .sp_o(sp_q), .ccr_o(ccr_q), .cycles_o(cyc_q)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] o);
    case (o)
      8'h84: return "R3";
      8'h85: return "R4";
      8'h97, 8'h9F: return "R5";
      8'h95: return "R6";
      8'h94: return "R7";
      8'h4D, 8'h5D, 8'h3D: return "R8/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] o, input logic [7:0] a, input logic [7:0] l,
                        input logic [7:0] h, input logic [15:0] s, input logic [7:0] c,
                        input logic [7:0] m);
    logic [7:0] ea = a, el = l, eh = h, ec = c, opnd;
    logic [15:0] es = s;
    logic [2:0] ey = 3'd0;
    logic ei = 1'b0, tst = 1'b0;
    string r = req_of(o);
    case (o)
      8'h84: begin ec = a | 8'h60; ey = 1; end
      8'h85: begin ea = c; ey = 1; end
      8'h97: begin el = a; ey = 1; end
      8'h9F: begin ea = l; ey = 1; end
      8'h95: begin {eh, el} = s + 16'd1; ey = 2; end
      8'h94: begin es = {h, l} - 16'd1; ey = 2; end
      8'h4D: begin opnd = a; tst = 1; ey = 1; end
      8'h5D: begin opnd = l; tst = 1; ey = 1; end
      8'h3D: begin opnd = m; tst = 1; ey = 4; end
      default: ei = 1'b1;
    endcase
    if (tst) begin ec[7] = 1'b0; ec[2] = opnd[7]; ec[1] = (opnd == 8'h00); end
    @(negedge clk);
    opc = o; acc = a; lo = l; hi = h; sp = s; ccr = c; mem = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "done", done, 1'b1);
    check(r, "illegal", illegal, ei);
    check(r, "acc", acc_q, ea);
    check(r, "idx_lo", lo_q, el);
    check(r, "idx_hi", hi_q, eh);
    check(r, "sp", sp_q, es);
    check(r, "ccr", ccr_q, ec);
    check(r, "cycles", cyc_q, ey);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] legal [9] = '{8'h84, 8'h85, 8'h97, 8'h9F, 8'h95, 8'h94, 8'h4D, 8'h5D, 8'h3D};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", done, 0);
    check("R1", "illegal", illegal, 0);
    check("R1", "acc", acc_q, 0);
    check("R1", "sp", sp_q, 0);
    check("R1", "ccr", ccr_q, 0);
    check("R1", "cycles", cyc_q, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run_op(8'h95, 8'h11, 8'h22, 8'h33, 16'hFFFF, 8'h60, 8'h00);  // R6 wrap
    run_op(8'h94, 8'h11, 8'h00, 8'h00, 16'h1234, 8'h60, 8'h00);  // R7 wrap
    run_op(8'h84, 8'h00, 8'h00, 8'h00, 16'h0000, 8'hFF, 8'h00);  // R3 forced bits
    run_op(8'h84, 8'h9F, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00);  // R3
    run_op(8'h4D, 8'h00, 8'h80, 8'h00, 16'h0000, 8'hFF, 8'h80);  // R8 zero
    run_op(8'h5D, 8'h00, 8'h80, 8'h00, 16'h0000, 8'h60, 8'h00);  // R9 index operand
    run_op(8'h3D, 8'h80, 8'h80, 8'h00, 16'h0000, 8'hE0, 8'h00);  // R9 memory operand
    run_op(8'h85, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h6B, 8'h00);  // R4
    run_op(8'h00, 8'h12, 8'h34, 8'h56, 16'h789A, 8'h61, 8'h00);  // R10

    // R2 hold while idle with changed inputs
    @(negedge clk);
    opc = 8'h85; acc = 8'hAA; ccr = 8'h55; sp = 16'h4321;
    @(negedge clk);
    check("R2", "done idle", done, 0);
    check("R2", "acc hold", acc_q, 8'h12);
    check("R2", "sp hold", sp_q, 16'h789A);
    check("R2", "ccr hold", ccr_q, 8'h61);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] o;
      o = ($urandom % 4 == 0) ? 8'($urandom) : legal[$urandom % 9];
      run_op(o, 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
             8'($urandom), ($urandom % 5 == 0) ? 8'h00 : 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule